// File: doc/BRIEF.md
# Configurable UART Character Framer

This block turns one parallel character at a time into an asynchronous serial frame. A frame is a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then the stop period at the high level. When no frame is being sent, the line sits high. A small set of line-control inputs sets the frame shape. The length code picks 5 to 8 data bits. A stop selector picks one or two stop bits. A parity enable turns the parity bit on, and a sense bit picks even or odd parity. All bit timing comes from a baud tick input that pulses 16 times per bit.

Characters come in over a valid/ready stream interface. A transfer happens on a rising clock edge where `in_valid` and `in_ready` are both high. The producer must hold `in_data` and the control inputs steady while `in_valid` is high and `in_ready` is low. `in_ready` stays low from the cycle the start bit begins until the last stop tick has been counted. This is the only back-pressure the block applies, and a waiting producer is never dropped. The control inputs are captured only at the transfer edge. Changing them while a frame is on the line has no effect on that frame.

Top module: `uart_char_framer`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0 and `in_ready` is 1. The line stays high whenever no frame is in progress.
- R2: A character is taken only on an edge with `in_valid` and `in_ready` both high. `in_ready` stays low from that edge until the last stop tick, so a held `in_valid` waits, and its character follows right after the current frame.
- R3: From the clock after a transfer, `txd` is low for 16 baud ticks. After that, each data bit is driven for 16 ticks, starting with `in_data[0]`.
- R4: `cfg_len` sets the number of data bits: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Data bits above the chosen length are never sent.
- R5: With `cfg_two_stop`=0 the stop period is 16 ticks at level 1. With `cfg_two_stop`=1 and `cfg_len` not 2'b00, it is 32 ticks.
- R6: With `cfg_two_stop`=1 and `cfg_len`=2'b00, the stop period is one and a half bit times, which is 24 ticks.
- R7: With `cfg_par_en`=1, a 16-tick parity bit is sent between the last data bit and the stop period. With `cfg_par_en`=0, no parity bit is sent.
- R8: The parity bit covers only the active data bits. With `cfg_par_even`=1 it makes the total count of ones even; with `cfg_par_even`=0 it makes that count odd.
- R9: The control inputs are sampled only on the transfer edge. Changes made during a frame do not alter its length, parity or stop period.
- R10: Frame timing moves only on clock edges where `baud_tick` is high. Without ticks, `txd` and `in_ready` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Character to send, bit 0 goes out first |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | Framer can take a character this cycle |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| cfg_len | input | 2 | Data length code (5 + code bits) |
| cfg_two_stop | input | 1 | 0: one stop bit, 1: two (1.5 for 5-bit) |
| cfg_par_en | input | 1 | 1: append a parity bit |
| cfg_par_even | input | 1 | 1: even parity, 0: odd parity |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | A frame is on the line |

## Verification
The bench builds the framer with its default parameters: 16 ticks per bit and an 8-bit data path. With these values, all four length codes, both stop settings and the 24-tick stop are covered with the real tick counts. Tick spacing varies from one clock to several clocks, and some runs pause the ticks in the middle of a frame. This shows that timing follows the tick input and not the clock. Runs with back-to-back transfers and runs that change the control inputs during a frame exercise the back-pressure and capture-at-transfer rules.

// File: rtl/framer_pkg.sv
package framer_pkg;

  // Width of the line-control length code
  localparam int LEN_W = 2;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PARITY,
    PH_STOP
  } phase_e;

  // Frame settings captured when a character is accepted
  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             two_stop;
    logic             par_en;
    logic             par_bit;
  } held_cfg_t;

endpackage

// File: rtl/framer_parity.sv
module framer_parity #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic [DATA_W-1:0] data,
  input  logic [IDX_W-1:0]  count,
  input  logic              even,
  output logic              par_bit
);

  logic [DATA_W-1:0] masked;

  // Only bits below the active length take part in the parity sum
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign masked[i] = data[i] & (IDX_W'(i) < count);
  end

  // Even sense: parity equals the sum, so the total count of ones is even
  assign par_bit = even ? (^masked) : ~(^masked);

endmodule

// File: rtl/framer_cfg_hold.sv
module framer_cfg_hold
  import framer_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16,
  parameter int IDX_W         = 4,
  parameter int CNT_W         = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  held_cfg_t        cfg_in,
  output logic [IDX_W-1:0] data_count,
  output logic [CNT_W-1:0] stop_ticks,
  output logic             par_en,
  output logic             par_bit
);

  localparam int MIN_BITS   = DATA_W - 3;
  localparam int STOP_ONE   = TICKS_PER_BIT;
  localparam int STOP_TWO   = 2 * TICKS_PER_BIT;
  localparam int STOP_HALF3 = (3 * TICKS_PER_BIT) / 2;

  held_cfg_t held_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     held_q <= '0;
    else if (load)  held_q <= cfg_in;
  end

  assign data_count = IDX_W'(MIN_BITS) + IDX_W'(held_q.len);
  assign par_en     = held_q.par_en;
  assign par_bit    = held_q.par_bit;

  always_comb begin
    if (!held_q.two_stop)         stop_ticks = CNT_W'(STOP_ONE);
    else if (held_q.len == '0)    stop_ticks = CNT_W'(STOP_HALF3);
    else                          stop_ticks = CNT_W'(STOP_TWO);
  end

  // R9
  cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(held_q));

endmodule

// File: rtl/framer_tick_timer.sv
module framer_tick_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  assign done = running && tick && (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !running || done) cnt <= '0;
    else if (tick)                  cnt <= cnt + CNT_W'(1);
  end

  // R10
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt < limit));

  // R10
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !tick && $past(running)) |=> (cnt == $past(cnt)) || !running);

endmodule

// File: rtl/uart_char_framer.sv
module uart_char_framer
  import framer_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              baud_tick,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_two_stop,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  output logic              txd,
  output logic              busy
);

  localparam int IDX_W    = $clog2(DATA_W + 1);
  localparam int CNT_W    = $clog2(2 * TICKS_PER_BIT + 1);
  localparam int MIN_BITS = DATA_W - 3;

  phase_e            phase;
  logic [IDX_W-1:0]  bit_idx;
  logic [DATA_W-1:0] shreg;
  logic              txd_q;
  logic              accept;
  logic              tick_done;
  logic [CNT_W-1:0]  limit;
  logic [IDX_W-1:0]  data_count;
  logic [CNT_W-1:0]  stop_ticks;
  logic              par_en;
  logic              par_bit;
  logic              new_par;
  held_cfg_t         cfg_in;

  assign busy     = (phase != PH_IDLE);
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign txd      = txd_q;

  // Parity of the incoming character, using the length it arrives with
  framer_parity #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_parity (
    .data    (in_data),
    .count   (IDX_W'(MIN_BITS) + IDX_W'(cfg_len)),
    .even    (cfg_par_even),
    .par_bit (new_par)
  );

  assign cfg_in = '{len: cfg_len, two_stop: cfg_two_stop,
                    par_en: cfg_par_en, par_bit: new_par};

  framer_cfg_hold #(
    .DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT),
    .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .cfg_in     (cfg_in),
    .data_count (data_count),
    .stop_ticks (stop_ticks),
    .par_en     (par_en),
    .par_bit    (par_bit)
  );

  assign limit = (phase == PH_STOP) ? stop_ticks : CNT_W'(TICKS_PER_BIT);

  framer_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .running (busy),
    .tick    (baud_tick),
    .limit   (limit),
    .done    (tick_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      bit_idx <= '0;
      shreg   <= '0;
      txd_q   <= 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: if (accept) begin
          phase   <= PH_START;
          shreg   <= in_data;
          bit_idx <= '0;
          txd_q   <= 1'b0;
        end
        PH_START: if (tick_done) begin
          phase <= PH_DATA;
          txd_q <= shreg[0];
        end
        PH_DATA: if (tick_done) begin
          if (bit_idx == data_count - IDX_W'(1)) begin
            if (par_en) begin
              phase <= PH_PARITY;
              txd_q <= par_bit;
            end else begin
              phase <= PH_STOP;
              txd_q <= 1'b1;
            end
          end else begin
            bit_idx <= bit_idx + IDX_W'(1);
            shreg   <= shreg >> 1;
            txd_q   <= shreg[1];
          end
        end
        PH_PARITY: if (tick_done) begin
          phase <= PH_STOP;
          txd_q <= 1'b1;
        end
        PH_STOP: if (tick_done) begin
          phase <= PH_IDLE;
          txd_q <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!txd && busy));

  // R2
  hold_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(phase == PH_STOP && tick_done)) |=> !in_ready);

  // R5
  stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STOP) |-> txd);

  // R4
  bit_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA) |-> (bit_idx < data_count));

endmodule

// File: tb/test_uart_char_framer.sv
module test_uart_char_framer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       baud_tick = 1'b0;
  logic [1:0] cfg_len = '0;
  logic       cfg_two_stop = 1'b0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       txd;
  logic       busy;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  uart_char_framer i_uart_char_framer (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .baud_tick(baud_tick), .cfg_len(cfg_len),
    .cfg_two_stop(cfg_two_stop), .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even), .txd(txd), .busy(busy)
  );

  // Baud tick source: one pulse every tick_div clocks unless paused
  int  tick_div = 1;
  bit  tick_pause = 0;
  int  div_cnt = 0;
  always @(negedge clk) begin
    if (tick_pause) baud_tick = 1'b0;
    else begin
      div_cnt = div_cnt + 1;
      if (div_cnt >= tick_div) begin div_cnt = 0; baud_tick = 1'b1; end
      else baud_tick = 1'b0;
    end
  end

  // Reference model: list of line segments (level, length in ticks, tag)
  int    seg_lvl[$];
  int    seg_dur[$];
  string seg_tag[$];
  bit    m_busy = 0;
  int    m_cnt  = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      seg_lvl.delete(); seg_dur.delete(); seg_tag.delete();
      m_busy = 0; m_cnt = 0;
    end else if (!m_busy) begin
      if (in_valid) begin
        int n;
        int ones;
        n = 5 + int'(cfg_len);
        ones = 0;
        seg_lvl.push_back(0); seg_dur.push_back(16); seg_tag.push_back("R3 start");
        for (int i = 0; i < n; i++) begin
          seg_lvl.push_back(int'(in_data[i])); seg_dur.push_back(16);
          seg_tag.push_back("R3/R4 data");
          ones += int'(in_data[i]);
        end
        if (cfg_par_en) begin
          seg_lvl.push_back(cfg_par_even ? (ones % 2) : 1 - (ones % 2));
          seg_dur.push_back(16); seg_tag.push_back("R7/R8 parity");
        end
        seg_lvl.push_back(1);
        if (!cfg_two_stop) begin seg_dur.push_back(16); seg_tag.push_back("R5 stop"); end
        else if (cfg_len == 2'b00) begin seg_dur.push_back(24); seg_tag.push_back("R6 stop"); end
        else begin seg_dur.push_back(32); seg_tag.push_back("R5 stop"); end
        m_busy = 1; m_cnt = 0;
      end
    end else if (baud_tick) begin
      m_cnt = m_cnt + 1;
      if (m_cnt == seg_dur[0]) begin
        void'(seg_lvl.pop_front()); void'(seg_dur.pop_front()); void'(seg_tag.pop_front());
        m_cnt = 0;
        if (seg_lvl.size() == 0) m_busy = 0;
      end
    end
  end

  // Compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      logic  exp_txd;
      string tag;
      exp_txd = m_busy ? logic'(seg_lvl[0][0]) : 1'b1;
      tag     = m_busy ? seg_tag[0] : "R1 idle";
      checks++;
      if (txd !== exp_txd) begin
        errors++;
        $display("FAIL %s (%s) txd=%b expected %b at %0t", tag, cur_req, txd, exp_txd, $time);
      end
      checks++;
      if (in_ready !== !m_busy || busy !== m_busy) begin
        errors++;
        $display("FAIL R2 (%s) in_ready=%b busy=%b expected ready=%b busy=%b at %0t",
                 cur_req, in_ready, busy, !m_busy, m_busy, $time);
      end
    end
  end

  // Offer one character; returns after the transfer edge
  task automatic send(input logic [7:0] d, input logic [1:0] len, input logic two,
                      input logic pe, input logic pev, input bit scramble);
    @(negedge clk);
    in_data = d; cfg_len = len; cfg_two_stop = two; cfg_par_en = pe; cfg_par_even = pev;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (scramble) begin
      in_data = ~d; cfg_len = ~len; cfg_two_stop = ~two; cfg_par_en = ~pe; cfg_par_even = ~pev;
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);

    // R3: start bit and LSB-first data, 8 bits, fast ticks
    cur_req = "R3"; tick_div = 1;
    send(8'hA5, 2'b11, 1'b0, 1'b0, 1'b0, 0); wait_idle();

    // R4: each length code, upper bits set that must not appear
    cur_req = "R4"; tick_div = 2;
    send(8'hE6, 2'b00, 1'b0, 1'b0, 1'b0, 0); wait_idle();
    send(8'hD9, 2'b01, 1'b0, 1'b0, 1'b0, 0); wait_idle();
    send(8'hB3, 2'b10, 1'b0, 1'b0, 1'b0, 0); wait_idle();

    // R7 R8: parity on/off, even and odd, with ignored upper bits
    cur_req = "R8"; tick_div = 1;
    send(8'h37, 2'b11, 1'b0, 1'b1, 1'b1, 0); wait_idle();
    send(8'h37, 2'b11, 1'b0, 1'b1, 1'b0, 0); wait_idle();
    send(8'hE1, 2'b00, 1'b0, 1'b1, 1'b1, 0); wait_idle();
    send(8'h20, 2'b00, 1'b0, 1'b1, 1'b0, 0); wait_idle();
    cur_req = "R7";
    send(8'h00, 2'b10, 1'b0, 1'b1, 1'b0, 0); wait_idle();

    // R5 R6: stop period lengths
    cur_req = "R5"; tick_div = 3;
    send(8'h5A, 2'b11, 1'b1, 1'b0, 1'b0, 0); wait_idle();
    send(8'h0F, 2'b10, 1'b1, 1'b1, 1'b1, 0); wait_idle();
    cur_req = "R6";
    send(8'h15, 2'b00, 1'b1, 1'b0, 1'b0, 0); wait_idle();
    send(8'h0A, 2'b00, 1'b1, 1'b1, 1'b0, 0); wait_idle();

    // R9: control inputs flipped during the frame
    cur_req = "R9"; tick_div = 1;
    send(8'h3C, 2'b00, 1'b1, 1'b1, 1'b1, 1); wait_idle();
    send(8'hC3, 2'b11, 1'b0, 1'b0, 1'b0, 1); wait_idle();

    // R2: back-to-back transfers with in_valid held under back-pressure
    cur_req = "R2"; tick_div = 2;
    send(8'h81, 2'b11, 1'b0, 1'b0, 1'b0, 0);
    send(8'h7E, 2'b01, 1'b1, 1'b1, 1'b1, 0);
    send(8'h55, 2'b00, 1'b1, 1'b0, 1'b0, 0);
    wait_idle();

    // R10: ticks paused in mid-frame
    cur_req = "R10"; tick_div = 1;
    send(8'h96, 2'b11, 1'b0, 1'b1, 1'b0, 0);
    repeat (60) @(negedge clk);
    tick_pause = 1;
    repeat (40) @(negedge clk);
    tick_pause = 0;
    wait_idle();

    ended = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      errors++;
      $display("FAIL watchdog (%s) actual=hung expected=done", cur_req);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule